// File: doc/BRIEF.md
# Bulk Command Stream Register Decoder

This block sits behind the endpoint that receives bulk transfers for a display controller. It takes the command byte stream one byte per valid/ready handshake, frames packets on a fixed lead byte, and turns register-write packets into writes to a 256-entry byte-wide video register file. A lock/unlock pair written to the top pseudo-register stages a whole mode change: while the bank is locked, writes land only in a shadow copy, and the unlock write moves the whole shadow into the live registers in a single clock cycle. A timing generator downstream therefore never sees a half-programmed mode.

The same parser recognises the short memory-copy packet and reports its source address, pixel count and destination address as a one-cycle descriptor. The live blank-mode register and the two segment base addresses are brought out as dedicated outputs, and any live register can be read through a one-cycle read port.

Top module: `bulk_cmd_decoder`

## Requirements
- R1: After reset every live register reads 0x00, the bank is unlocked, `in_ready` is 1, and `cp_valid` is 0.
- R2: The four-byte packet 0xAF, 0x20, addr, value written while unlocked updates live register addr; the new value is visible one cycle after the edge that accepts the value byte, not at that edge.
- R3: A register write of 0x00 to address 0xFF locks the bank; while locked, writes to addresses 0x00..0xFE change only the shadow, and the live registers and the `blank_mode`, `base16`, `base8` outputs hold.
- R4: A register write of 0xFF to address 0xFF unlocks the bank and copies all shadow entries into the live registers together, visible one cycle after the edge that accepts the unlock value byte; entries written before the lock keep their values.
- R5: Writes to address 0xFF with any value other than 0x00 or 0xFF have no effect, and address 0xFF is never stored: it always reads back 0x00.
- R6: `blank_mode` equals live register 0x1F (0x00 syncs on, 0x01 suspend, 0x05 standby, 0x07 powerdown, passed unchanged), and `video_on` is 1 exactly when that register is 0x00.
- R7: `base16` is {reg 0x20, reg 0x21, reg 0x22} and `base8` is {reg 0x26, reg 0x27, reg 0x28}, the lower address holding the most significant byte.
- R8: The nine-byte packet 0xAF, 0x6A, s2, s1, s0, n, d2, d1, d0 raises `cp_valid` for exactly one cycle after the edge accepting d0, with `cp_src`={s2,s1,s0}, `cp_count`=n, `cp_dst`={d2,d1,d0}; payload bytes equal to 0xAF or 0x20 are data, not framing.
- R9: After 0xAF followed by a code other than 0x20, 0x6A or 0xAF, all bytes up to the next 0xAF are discarded without any register write.
- R10: An 0xAF received where a command code is expected is treated as a fresh lead byte, so a lone padding 0xAF before the next packet is ignored; non-0xAF bytes between packets are also ignored.
- R11: `rd_data` returns live register `rd_addr` one cycle after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a byte (high outside reset) |
| rd_addr | input | 8 | Live register read address |
| rd_data | output | 8 | Live register value, one cycle after rd_addr |
| locked | output | 1 | Bank is locked; writes go to the shadow only |
| blank_mode | output | 8 | Live blank-mode register |
| video_on | output | 1 | Blank-mode register selects syncs on |
| base16 | output | 24 | Live 16-bpp segment base address |
| base8 | output | 24 | Live 8-bpp segment base address |
| cp_valid | output | 1 | One-cycle copy descriptor strobe |
| cp_src | output | 24 | Copy source address |
| cp_count | output | 8 | Copy pixel count |
| cp_dst | output | 24 | Copy destination address |

## Verification
The bench builds the block with its default 8-bit register address, which makes the whole 256-entry file small enough to write and read back completely, so every address including the pseudo-register is swept. Expected register contents come from a bench-side model of the live and shadow banks, so the locked mode-set sequence is checked address by address, and the cycle right before and right after the unlock are both sampled. Copy descriptors, unknown codes and padding leads are fed with payloads that contain framing byte values.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam logic [7:0] LEAD_BYTE = 8'hAF;
  localparam logic [7:0] OP_REGWR  = 8'h20;
  localparam logic [7:0] OP_COPY   = 8'h6A;
  localparam logic [7:0] LOCK_VAL   = 8'h00;
  localparam logic [7:0] UNLOCK_VAL = 8'hFF;
  localparam int COPY_BYTES = 7;

  typedef enum logic [2:0] {
    P_IDLE, P_CODE, P_ADDR, P_VAL, P_COPY, P_SKIP
  } pstate_t;
endpackage

// File: rtl/bcd_parser.sv
module bcd_parser
  import bcd_pkg::*;
#(
  parameter int PAYLOAD_BYTES = COPY_BYTES
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic        wr_vld,
  output logic [7:0]  wr_addr,
  output logic [7:0]  wr_data,
  output logic        cp_vld,
  output logic [23:0] cp_src,
  output logic [7:0]  cp_cnt,
  output logic [23:0] cp_dst
);
  localparam int HOLD_W = 8 * (PAYLOAD_BYTES - 1);
  localparam int CNT_W  = $clog2(PAYLOAD_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAYLOAD_BYTES - 1);

  pstate_t            st_q;
  logic [7:0]         addr_q;
  logic [HOLD_W-1:0]  hold_q;
  logic [CNT_W-1:0]   idx_q;
  logic [HOLD_W+7:0]  full_w;

  assign full_w = {hold_q, byte_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= P_IDLE;
      addr_q  <= '0;
      hold_q  <= '0;
      idx_q   <= '0;
      wr_vld  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      cp_vld  <= 1'b0;
      cp_src  <= '0;
      cp_cnt  <= '0;
      cp_dst  <= '0;
    end else begin
      wr_vld <= 1'b0;
      cp_vld <= 1'b0;
      if (byte_vld) begin
        case (st_q)
          P_IDLE, P_SKIP: begin
            if (byte_in == LEAD_BYTE) st_q <= P_CODE;
          end
          P_CODE: begin
            if (byte_in == OP_REGWR) st_q <= P_ADDR;
            else if (byte_in == OP_COPY) begin
              st_q  <= P_COPY;
              idx_q <= '0;
            end
            else if (byte_in == LEAD_BYTE) st_q <= P_CODE;
            else st_q <= P_SKIP;
          end
          P_ADDR: begin
            addr_q <= byte_in;
            st_q   <= P_VAL;
          end
          P_VAL: begin
            wr_vld  <= 1'b1;
            wr_addr <= addr_q;
            wr_data <= byte_in;
            st_q    <= P_IDLE;
          end
          P_COPY: begin
            hold_q <= full_w[HOLD_W-1:0];
            if (idx_q == LAST_IDX) begin
              cp_vld <= 1'b1;
              cp_src <= full_w[55:32];
              cp_cnt <= full_w[31:24];
              cp_dst <= full_w[23:0];
              st_q   <= P_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: st_q <= P_IDLE;
        endcase
      end
    end
  end

  // R2: a write packet spans four bytes, so strobes never repeat back to back
  a_r2_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_vld |=> !wr_vld);
  // R8: descriptor strobe lasts one cycle
  a_r8_copy_single: assert property (@(posedge clk) disable iff (rst)
    cp_vld |=> !cp_vld);
  // R8: a copy and a write never finish in the same cycle
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cp_vld && wr_vld));
endmodule

// File: rtl/bcd_regbank.sv
module bcd_regbank
  import bcd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          locked,
  output logic [7:0]    blank_mode,
  output logic [23:0]   base16,
  output logic [23:0]   base8
);
  localparam int DEPTH = 2 ** AW;
  localparam logic [AW-1:0] LOCK_IDX  = AW'(DEPTH - 1);
  localparam logic [AW-1:0] BLANK_IDX = AW'(8'h1F);
  localparam int B16 = 32'h20;
  localparam int B8  = 32'h26;

  logic [7:0] live_q [DEPTH];
  logic [7:0] shad_q [DEPTH];
  logic       lock_q;
  logic       ctl_wr;

  assign ctl_wr = wr_vld && (wr_addr == LOCK_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        live_q[i] <= '0;
        shad_q[i] <= '0;
      end
    end else if (ctl_wr) begin
      if (wr_data == LOCK_VAL) begin
        lock_q <= 1'b1;
      end else if (wr_data == UNLOCK_VAL) begin
        lock_q <= 1'b0;
        for (int i = 0; i < DEPTH; i++) live_q[i] <= shad_q[i];
      end
    end else if (wr_vld) begin
      shad_q[wr_addr] <= wr_data;
      if (!lock_q) live_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= live_q[rd_addr];
  end

  assign locked     = lock_q;
  assign blank_mode = live_q[BLANK_IDX];
  assign base16     = {live_q[B16], live_q[B16+1], live_q[B16+2]};
  assign base8      = {live_q[B8],  live_q[B8+1],  live_q[B8+2]};

  // R3: while locked and no unlock arrives, the timing-facing outputs hold
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !(ctl_wr && wr_data == UNLOCK_VAL)) |=>
      ($stable(blank_mode) && $stable(base16) && $stable(base8)));
  // R3: lock value engages the lock
  a_r3_lock_sets: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data == LOCK_VAL) |=> locked);
  // R4: unlock value releases the lock
  a_r4_unlock_clears: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data == UNLOCK_VAL) |=> !locked);
  // R5: other values at the pseudo-register leave the lock alone
  a_r5_other_keeps: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data != LOCK_VAL && wr_data != UNLOCK_VAL) |=> $stable(locked));
endmodule

// File: rtl/bulk_cmd_decoder.sv
module bulk_cmd_decoder
  import bcd_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              locked,
  output logic [7:0]        blank_mode,
  output logic              video_on,
  output logic [23:0]       base16,
  output logic [23:0]       base8,
  output logic              cp_valid,
  output logic [23:0]       cp_src,
  output logic [7:0]        cp_count,
  output logic [23:0]       cp_dst
);
  logic       rdy_q;
  logic       take;
  logic       wr_vld;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign take     = in_valid && rdy_q;

  bcd_parser #(.PAYLOAD_BYTES(COPY_BYTES)) i_parser (
    .clk     (clk),
    .rst     (rst),
    .byte_vld(take),
    .byte_in (in_data),
    .wr_vld  (wr_vld),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cp_vld  (cp_valid),
    .cp_src  (cp_src),
    .cp_cnt  (cp_count),
    .cp_dst  (cp_dst)
  );

  bcd_regbank #(.AW(REG_AW)) i_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_vld    (wr_vld),
    .wr_addr   (REG_AW'(wr_addr)),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .locked    (locked),
    .blank_mode(blank_mode),
    .base16    (base16),
    .base8     (base8)
  );

  assign video_on = (blank_mode == 8'h00);

  // R6: video_on tracks the blank register
  a_r6_video_on: assert property (@(posedge clk) disable iff (rst)
    video_on == (blank_mode == 8'h00));
endmodule

// File: tb/test_bulk_cmd_decoder.sv
module test_bulk_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic [7:0]  rd_addr;
  logic [7:0]  rd_data;
  logic        locked;
  logic [7:0]  blank_mode;
  logic        video_on;
  logic [23:0] base16, base8;
  logic        cp_valid;
  logic [23:0] cp_src, cp_dst;
  logic [7:0]  cp_count;

  always #2 clk = ~clk;

  bulk_cmd_decoder i_bulk_cmd_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .locked(locked), .blank_mode(blank_mode), .video_on(video_on),
    .base16(base16), .base8(base8), .cp_valid(cp_valid), .cp_src(cp_src),
    .cp_count(cp_count), .cp_dst(cp_dst)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_live [256];
  logic [7:0] m_shad [256];
  bit m_lock;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  // model follows R2..R5
  task automatic model_wr(input logic [7:0] a, input logic [7:0] v);
    if (a == 8'hFF) begin
      if (v == 8'h00) m_lock = 1'b1;
      else if (v == 8'hFF) begin
        m_lock = 1'b0;
        for (int i = 0; i < 256; i++) m_live[i] = m_shad[i];
      end
    end else begin
      m_shad[a] = v;
      if (!m_lock) m_live[a] = v;
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] v);
    put(8'hAF); put(8'h20); put(a); put(v);
    settle();
    model_wr(a, v);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #1;
    chk(req, {24'h0, rd_data}, {24'h0, m_live[a]});
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 256; a++) rd_chk(req, 8'(a));
  endtask

  task automatic views_chk(input string req);
    chk({req, " R6 blank"}, {24'h0, blank_mode}, {24'h0, m_live[8'h1F]});
    chk({req, " R6 video_on"}, {31'h0, video_on}, {31'h0, m_live[8'h1F] == 8'h00});
    chk({req, " R7 base16"}, {8'h0, base16}, {8'h0, m_live[8'h20], m_live[8'h21], m_live[8'h22]});
    chk({req, " R7 base8"}, {8'h0, base8}, {8'h0, m_live[8'h26], m_live[8'h27], m_live[8'h28]});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; rd_addr = '0;
    for (int i = 0; i < 256; i++) begin m_live[i] = '0; m_shad[i] = '0; end
    m_lock = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    settle();
    // R1 reset state
    chk("R1 ready", {31'h0, in_ready}, 32'h1);
    chk("R1 locked", {31'h0, locked}, 32'h0);
    chk("R1 cp_valid", {31'h0, cp_valid}, 32'h0);
    sweep("R1 R11 reset read");
    views_chk("R1");

    // R2 timing of a single write
    put(8'hAF); put(8'h20); put(8'h1F); put(8'h01);
    chk("R2 not yet live", {24'h0, blank_mode}, 32'h0);
    settle();
    model_wr(8'h1F, 8'h01);
    chk("R2 live next cycle", {24'h0, blank_mode}, 32'h01);

    // R2 R5 R11 unlocked sweep over all addresses
    for (int a = 0; a < 256; a++) reg_wr(8'(a), 8'(a * 7 + 3));
    sweep("R2 R5 R11 unlocked sweep");
    views_chk("R2");

    // R5 other control values ignored
    reg_wr(8'hFF, 8'h12);
    chk("R5 lock unchanged", {31'h0, locked}, 32'h0);
    reg_wr(8'h1F, 8'h05);
    views_chk("R5 still unlocked");
    rd_chk("R5 ctl reads zero", 8'hFF);

    // R3 locked mode-set
    reg_wr(8'hFF, 8'h00);
    chk("R3 locked", {31'h0, locked}, 32'h1);
    reg_wr(8'h1F, 8'h07); views_chk("R3 hold");
    reg_wr(8'h20, 8'h12); reg_wr(8'h21, 8'h34); reg_wr(8'h22, 8'h56);
    views_chk("R3 hold");
    reg_wr(8'h26, 8'hAB); reg_wr(8'h27, 8'hCD); reg_wr(8'h28, 8'hEF);
    for (int a = 1; a < 24; a += 2) reg_wr(8'(a), 8'(a ^ 8'h5A));
    views_chk("R3 hold");
    sweep("R3 live unchanged");

    // R4 unlock: old values one cycle, new values the next
    put(8'hAF); put(8'h20); put(8'hFF); put(8'hFF);
    chk("R4 before copy", {24'h0, blank_mode}, {24'h0, m_live[8'h1F]});
    chk("R4 before copy lock", {31'h0, locked}, 32'h1);
    settle();
    model_wr(8'hFF, 8'hFF);
    chk("R4 blank 07", {24'h0, blank_mode}, 32'h07);
    chk("R6 powerdown video off", {31'h0, video_on}, 32'h0);
    chk("R7 base16", {8'h0, base16}, 32'h123456);
    chk("R7 base8", {8'h0, base8}, 32'hABCDEF);
    chk("R4 unlocked", {31'h0, locked}, 32'h0);
    sweep("R4 after unlock");

    // R8 copy descriptors
    put(8'hAF); put(8'h6A); put(8'h01); put(8'h02); put(8'h03);
    put(8'h04); put(8'h05); put(8'h06); put(8'h07);
    chk("R8 strobe", {31'h0, cp_valid}, 32'h1);
    chk("R8 src", {8'h0, cp_src}, 32'h010203);
    chk("R8 count", {24'h0, cp_count}, 32'h04);
    chk("R8 dst", {8'h0, cp_dst}, 32'h050607);
    settle();
    chk("R8 one cycle", {31'h0, cp_valid}, 32'h0);
    put(8'hAF); put(8'h6A); put(8'hAF); put(8'h20); put(8'h1F);
    put(8'h00); put(8'hAF); put(8'hAF); put(8'h20);
    chk("R8 framing bytes as data", {8'h0, cp_src}, 32'hAF201F);
    chk("R8 dst framing", {8'h0, cp_dst}, 32'hAFAF20);
    settle();
    views_chk("R8 no write");

    // R9 unknown code skipped
    put(8'hAF); put(8'h33); put(8'h20); put(8'h1F); put(8'h00);
    settle();
    views_chk("R9 skipped");
    reg_wr(8'h1F, 8'h01);
    views_chk("R9 resync");

    // R10 padding lead and stray bytes
    put(8'hAF);
    reg_wr(8'h1F, 8'h00);
    views_chk("R10 lone lead");
    put(8'h55); put(8'hAF); put(8'hAF);
    put(8'h20); put(8'h1F); put(8'h05);
    settle();
    model_wr(8'h1F, 8'h05);
    views_chk("R10 double lead");
    rd_chk("R11 read blank", 8'h1F);

    summary();
  end
endmodule